// File: doc/BRIEF.md
# Scanline Sprite Serializer and Pixel Mixer

This block turns up to eight sprites into pixels along one scanline and mixes them over a background pixel stream. Each sprite lane holds a horizontal countdown, an 8-bit pattern shift register, an 8-bit holding latch for its next pattern byte, and a 5-bit attribute (palette, front/behind flag, opacity). During blanking a controller writes each lane's start position and attribute. Pattern bytes are then written from sprite graphics memory at one lane per clock.

Every pixel-advance cycle, each lane whose countdown has reached zero presents the most significant bit of its shift register and then shifts left. A byte waiting in a lane's holding latch moves into the shift register as soon as that register has emptied. This happens in the same cycle as the last bit leaves, so two bytes make one unbroken 16-pixel run. The lowest-numbered lane with an opaque pixel wins. Its result, or the background, is registered into an 8-bit output pixel latch.

Top module: `sprite_line_mixer`

## Requirements
- R1: After synchronous active-low reset `pix_out` is 0 and no lane shows a pixel, so background bytes pass straight through.
- R2: Writing a lane with `cfg_we` loads its start position X and its attribute, and empties its shift register and holding latch. The attribute layout is bit 4 opaque, bit 3 front, bits 2:0 palette. The lane's first pattern bit appears at pixel index X, where pixel index 0 is the first `pix_en` cycle after the write.
- R3: `pix_out` is registered. It changes only on a clock edge where `pix_en` is high and shows the pixel computed from the state and `bg_pix` at that edge. While `pix_en` is low, the output and every countdown and shift register hold.
- R4: A loaded pattern byte is shown over 8 consecutive pixels, most significant bit first. After that the lane is transparent unless another byte is waiting.
- R5: A byte written with `gfx_we` to lane `gfx_sel` goes into that lane's holding latch, one lane per clock. It moves into the shift register when that register is empty or is sending its last bit, so a second byte follows the first with no gap.
- R6: A lane whose opacity bit is clear never shows a pixel, whatever its pattern.
- R7: When several lanes are opaque on the same pixel, the lowest-numbered lane wins.
- R8: A winning lane with the front bit clear is drawn only where `bg_pix` is zero, and the background shows elsewhere. With the front bit set, the lane always covers the background.
- R9: A sprite pixel is output as `{1, 0000, palette[2:0]}`. When no lane is opaque, `bg_pix` is output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Lane setup write strobe |
| cfg_sel | input | 3 | Lane selected for setup |
| cfg_xpos | input | 9 | Start position for the selected lane |
| cfg_attr | input | 5 | Attribute: opaque, front, palette |
| gfx_we | input | 1 | Pattern byte write strobe |
| gfx_sel | input | 3 | Lane receiving the pattern byte |
| gfx_data | input | 8 | Pattern byte |
| pix_en | input | 1 | Pixel advance |
| bg_pix | input | 8 | Background pixel for this advance |
| pix_out | output | 8 | Registered mixed pixel |

## Verification
A single sprite with a mixed bit pattern and a nonzero start position shows the start offset, the MSB-first order and the gaps for transparent bits. A pause in the middle of that run shows that the output and the countdowns hold while `pix_en` is low. A lane given two bytes, one solid and one half-filled, tells a seamless hand-over from the holding latch apart from a one-pixel gap or a lost byte. Overlapping lanes with different palettes, a behind-the-background lane under alternating zero and nonzero background, and a lane with opacity cleared separate the lane order, the front/behind rule and the opacity gate from one another.

// File: rtl/sprm_pkg.sv
// Shared constants and types for the scanline sprite mixer.
// Assumes a 3-bit palette field; the attribute is {opaque, front, palette}.
package sprm_pkg;
    localparam int SPR_COUNT  = 8;
    localparam int SPR_XPOS_W = 9;
    localparam int SPR_PIX_W  = 8;
    localparam int SPR_PAL_W  = 3;

    typedef struct packed {
        logic                 opaque;
        logic                 front;
        logic [SPR_PAL_W-1:0] pal;
    } spr_attr_t;

    localparam int SPR_ATTR_W = $bits(spr_attr_t);
endpackage

// File: rtl/sprm_lane.sv
// One sprite lane: position countdown, pattern shift register, next-byte
// holding latch and attribute. Assumes setup writes come before the line;
// a setup write takes precedence over a transfer in the same cycle.
module sprm_lane
    import sprm_pkg::*;
#(
    parameter int XW = SPR_XPOS_W,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hit,
    input  logic [XW-1:0] cfg_x,
    input  spr_attr_t     cfg_attr,
    input  logic          gfx_hit,
    input  logic [PW-1:0] gfx_byte,
    input  logic          pix_en,
    output logic          lit,
    output spr_attr_t     attr_o
);
    localparam int BW = $clog2(PW + 1);
    localparam logic [XW-1:0] ONE_X  = XW'(1);
    localparam logic [BW-1:0] ONE_B  = BW'(1);
    localparam logic [BW-1:0] FULL_B = BW'(PW);

    logic [XW-1:0] cnt;
    logic [PW-1:0] shreg;
    logic [PW-1:0] nxt;
    logic [BW-1:0] left;
    logic          nxt_full;
    spr_attr_t     attr;

    logic at_x, has_bits, shift_now, empty_next, xfer;

    // Decode lane state into shift and hand-over conditions.
    always_comb begin
        at_x       = (cnt == '0);
        has_bits   = (left != '0);
        shift_now  = pix_en && at_x && has_bits;
        empty_next = !has_bits || (shift_now && (left == ONE_B));
        xfer       = !cfg_hit && nxt_full && empty_next;
    end

    // Position countdown and attribute register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            attr <= '0;
        end else if (cfg_hit) begin
            cnt  <= cfg_x;
            attr <= cfg_attr;
        end else if (pix_en && !at_x) begin
            cnt <= cnt - ONE_X;
        end
    end

    // Pattern shift register and remaining-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (cfg_hit) begin
            left <= '0;
        end else if (xfer) begin
            shreg <= nxt;
            left  <= FULL_B;
        end else if (shift_now) begin
            shreg <= {shreg[PW-2:0], 1'b0};
            left  <= left - ONE_B;
        end
    end

    // Next-byte holding latch filled from graphics memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt      <= '0;
            nxt_full <= 1'b0;
        end else begin
            if (gfx_hit) nxt <= gfx_byte;
            nxt_full <= gfx_hit || (nxt_full && !xfer && !cfg_hit);
        end
    end

    assign lit    = at_x && has_bits && shreg[PW-1] && attr.opaque;
    assign attr_o = attr;

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !at_x && !cfg_hit) |=> (cnt == $past(cnt) - ONE_X));
    a_r3_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !cfg_hit && !xfer) |=> ($stable(cnt) && $stable(left)));
    a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        left <= FULL_B);
    a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_bits && nxt_full && !cfg_hit) |=> (left == FULL_B));
    a_r6_opacity_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !attr.opaque |-> !lit);
endmodule

// File: rtl/sprm_pick.sv
// Fixed-priority selector: grants the lowest-numbered lane with an opaque
// pixel. Purely combinational; assumes nothing about the request pattern.
module sprm_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from lane 0 upward and keep the first request.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sprite_line_mixer.sv
// Scanline sprite serializer bank with background mixing. Holds one lane per
// sprite, selects the winning opaque pixel and registers the mixed byte.
// Assumes the pixel width leaves room for the flag bit and the palette.
module sprite_line_mixer
    import sprm_pkg::*;
#(
    parameter int NUM_SPR = SPR_COUNT,
    parameter int XPOS_W  = SPR_XPOS_W,
    parameter int PIX_W   = SPR_PIX_W,
    localparam int IDX_W  = $clog2(NUM_SPR),
    localparam int PAD_W  = PIX_W - 1 - SPR_PAL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_sel,
    input  logic [XPOS_W-1:0]     cfg_xpos,
    input  logic [SPR_ATTR_W-1:0] cfg_attr,
    input  logic                  gfx_we,
    input  logic [IDX_W-1:0]      gfx_sel,
    input  logic [7:0]            gfx_data,
    input  logic                  pix_en,
    input  logic [PIX_W-1:0]      bg_pix,
    output logic [PIX_W-1:0]      pix_out
);
    logic [NUM_SPR-1:0] lit;
    logic [NUM_SPR-1:0] grant;
    logic               any_lit;
    spr_attr_t          lane_attr [NUM_SPR];

    logic [SPR_PAL_W-1:0] win_pal;
    logic                 win_front;
    logic [PIX_W-1:0]     mix_pix;

    for (genvar g = 0; g < NUM_SPR; g++) begin : g_lane
        sprm_lane #(.XW(XPOS_W), .PW(8)) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (cfg_we && (cfg_sel == IDX_W'(g))),
            .cfg_x    (cfg_xpos),
            .cfg_attr (spr_attr_t'(cfg_attr)),
            .gfx_hit  (gfx_we && (gfx_sel == IDX_W'(g))),
            .gfx_byte (gfx_data),
            .pix_en   (pix_en),
            .lit      (lit[g]),
            .attr_o   (lane_attr[g])
        );
    end

    sprm_pick #(.N(NUM_SPR)) i_pick (
        .req   (lit),
        .grant (grant),
        .any   (any_lit)
    );

    // Gather palette and front flag of the granted lane.
    always_comb begin
        win_pal   = '0;
        win_front = 1'b0;
        for (int i = 0; i < NUM_SPR; i++) begin
            if (grant[i]) begin
                win_pal   = win_pal | lane_attr[i].pal;
                win_front = win_front | lane_attr[i].front;
            end
        end
    end

    // Choose between sprite byte and background.
    always_comb begin
        if (any_lit && (win_front || (bg_pix == '0)))
            mix_pix = {1'b1, {PAD_W{1'b0}}, win_pal};
        else
            mix_pix = bg_pix;
    end

    // Output pixel latch, advanced once per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_out <= '0;
        else if (pix_en) pix_out <= mix_pix;
    end

    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_out));
    a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~lit) == '0));
    a_r9_bg_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && (lit == '0)) |=> (pix_out == $past(bg_pix)));
    a_r9_sprite_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && (lit != '0) && (bg_pix[PIX_W-1] == 1'b0) && (bg_pix != '0))
        |=> (pix_out[PIX_W-1] == $past(win_front)));
endmodule

// File: tb/test_sprite_line_mixer.sv
module test_sprite_line_mixer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [8:0] cfg_xpos = '0;
    logic [4:0] cfg_attr = '0;
    logic       gfx_we = 1'b0;
    logic [2:0] gfx_sel = '0;
    logic [7:0] gfx_data = '0;
    logic       pix_en = 1'b0;
    logic [7:0] bg_pix = '0;
    logic [7:0] pix_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_e;
    string      mon_t;

    always #10 clk = ~clk;

    sprite_line_mixer i_sprite_line_mixer (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_xpos(cfg_xpos), .cfg_attr(cfg_attr),
        .gfx_we(gfx_we), .gfx_sel(gfx_sel), .gfx_data(gfx_data),
        .pix_en(pix_en), .bg_pix(bg_pix), .pix_out(pix_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_out=%02h expected %02h", tag, got, exp);
        end
    endtask

    // Monitor: pops the scoreboard one entry per pixel advance.
    always @(posedge clk) begin
        if (rst_n && pix_en) begin
            #2;
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: pix_out=%02h expected none", pix_out);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, pix_out, mon_e);
            end
        end
    end

    task automatic setup(input int idx, input int x, input logic [4:0] attr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_xpos = 9'(x); cfg_attr = attr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input int idx, input logic [7:0] b);
        @(negedge clk);
        gfx_we = 1'b1; gfx_sel = 3'(idx); gfx_data = b;
        @(negedge clk);
        gfx_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) setup(i, 0, 5'b0);
    endtask

    // Driver: one pixel advance with its expected output pushed to the queue.
    task automatic px(input logic [7:0] bg, input logic [7:0] e, input string tag);
        @(negedge clk);
        pix_en = 1'b1; bg_pix = bg;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic stop();
        @(negedge clk);
        pix_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Attribute {opaque, front, pal}
    function automatic logic [4:0] at(input bit op, input bit fr, input int pal);
        return {op, fr, 3'(pal)};
    endfunction

    initial begin
        logic [7:0] e;
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", pix_out, 8'h00);
        // R1: nothing loaded, background passes
        px(8'h5A, 8'h5A, "R1 pass");
        px(8'hC3, 8'hC3, "R1 pass");
        stop();

        // R2 R4 R9 with an R3 pause: lane 3 at X=2, palette 5, front
        clear_all();
        setup(3, 2, at(1, 1, 5));
        pat = 8'hB1;
        load(3, pat);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 12; p++) begin
            if (p == 6) begin
                @(negedge clk);
                pix_en = 1'b0;
                repeat (3) @(negedge clk);
                check("R3 hold", pix_out, e);
            end
            e = 8'h20;
            if (p >= 2 && p < 10 && pat[9 - p]) e = 8'h85;
            px(8'h20, e, (p < 2) ? "R2 start" : "R4 msb-first");
        end
        stop();

        // R5: two bytes back to back on lane 0 at X=1
        clear_all();
        setup(0, 1, at(1, 1, 2));
        load(0, 8'hFF);
        load(0, 8'h0F);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 19; p++) begin
            e = 8'h11;
            if ((p >= 1 && p <= 8) || (p >= 13 && p <= 16)) e = 8'h82;
            px(8'h11, e, "R5 seamless");
        end
        stop();

        // R7: lanes 2 and 5 overlap, lane 2 wins where both opaque
        clear_all();
        setup(2, 0, at(1, 1, 6));
        setup(5, 0, at(1, 1, 1));
        load(2, 8'hF0);
        load(5, 8'hFF);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 9; p++) begin
            e = (p < 4) ? 8'h86 : ((p < 8) ? 8'h81 : 8'h07);
            px(8'h07, e, "R7 lowest wins");
        end
        stop();

        // R8: lane 1 behind background, alternating zero / nonzero background
        clear_all();
        setup(1, 0, at(1, 0, 3));
        load(1, 8'hFF);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            px(p[0] ? 8'h44 : 8'h00, p[0] ? 8'h44 : 8'h83, "R8 behind");
        end
        stop();

        // R6: opacity clear, front set, solid pattern: never shows
        clear_all();
        setup(4, 0, at(0, 1, 7));
        load(4, 8'hFF);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 8; p++) px(8'h33, 8'h33, "R6 transparent");
        stop();

        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d entries left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule